// File: doc/BRIEF.md
# Management-Mode Entry Sequencer

The block accepts an active-low management interrupt request from logic outside the core clock domain. It then steps the core into management mode. The request pin is first passed through a multi-flop synchroniser. A high-to-low transition of the synchronised request records one pending request. When the sequencer is idle, it takes the pending request and runs a fixed handshake chain:

- a one-cycle pulse asking for the architectural state to be saved;
- a wait for the save-complete input;
- a one-cycle acknowledge bus-request pulse;
- a wait for the bus to report that the acknowledge is done;
- a one-cycle pulse that redirects execution to the management handler.

The block then stays in management mode until a resume input is seen.

The same request pin also acts as a reset-time strap. The level of the synchronised request is captured on the first clock after reset is released. If the request was active at that moment, the block raises a float-enable output, which tells the rest of the chip to place its outputs in high impedance. That output keeps its value until the next reset. A request that is already held active through reset release is counted only as the strap, not as an interrupt.

Top module: `mgmtIntSeq`

## Requirements
- R1: While `rstN` is low and on the first cycle after it, `saveReq`, `ackReq`, `handlerStart`, `mgmtActive` and `floatEn` are all 0.
- R2: When idle, a falling edge on `intReqN` makes `saveReq` go high after exactly SYNC_STAGES+2 rising clock edges (4 with the default of 2). Keeping `intReqN` low after that edge starts no further entry.
- R3: `saveReq` is high for exactly one cycle. `mgmtActive` is 1 from that cycle on.
- R4: `ackReq` pulses for one cycle, in the cycle after the first clock edge at which `saveDone` is 1 while the save is awaited. It never pulses before that.
- R5: `handlerStart` pulses for one cycle, in the cycle after the first clock edge at which `ackDone` is 1 while the acknowledge is awaited. `mgmtActive` stays 1 afterwards.
- R6: `saveDone` and `ackDone` have no effect outside their own wait steps. A `saveDone` or `ackDone` seen in the idle state, or an `ackDone` seen while the save is awaited, produces no `ackReq` or `handlerStart` pulse.
- R7: Request edges that arrive while `mgmtActive` is 1 are held as a single pending request. Once `resume` is seen in management mode, `mgmtActive` falls in the next cycle. If a request is pending, `saveReq` pulses one cycle after that. Several such edges give only one re-entry.
- R8: `resume` has no effect before management mode is reached. It does not clear `mgmtActive` and does not disturb the handshake chain.
- R9: `floatEn` takes the synchronised request level (1 when `intReqN` is low) at the first clock edge after `rstN` rises, and keeps that value until the next reset. A request held low across reset release starts no entry sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| intReqN | input | 1 | Asynchronous active-low management interrupt request, and reset-time strap |
| saveDone | input | 1 | State save has completed |
| ackDone | input | 1 | Acknowledge bus transaction has completed |
| resume | input | 1 | Leave management mode |
| saveReq | output | 1 | One-cycle request to save state |
| ackReq | output | 1 | One-cycle acknowledge transaction request |
| handlerStart | output | 1 | One-cycle pulse that starts the handler |
| mgmtActive | output | 1 | Sequencer is busy or in management mode |
| floatEn | output | 1 | Strap result: drive all outputs to high impedance |

## Verification
The entry chain is run with a range of save-complete and acknowledge-complete latencies, including zero. This separates a design that waits on each handshake from one that runs ahead or loses a done pulse.

Each pattern also sends zero, one or several request edges while in management mode. This shows whether requests are deferred and then collapsed into a single re-entry after resume, or dropped, or re-accepted too early.

Directed cases cover further behaviour:
- stray done and resume pulses outside their steps;
- a request held across reset release, which must act only as the strap;
- a later clean reset, which must clear the strap.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_SAVE_WAIT = 2'd1,
    ST_ACK_WAIT  = 2'd2,
    ST_MGMT      = 2'd3
  } seqState_t;

  // Strobes from the control FSM to the datapath registers.
  typedef struct packed {
    logic clrPending;
    logic fireSave;
    logic fireAck;
    logic fireStart;
  } seqStrobe_t;

endpackage

// File: rtl/mgmtDatapath.sv
module mgmtDatapath
  import mgmt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       intReqN,
  input  seqStrobe_t strobe,
  output logic       pendingReq,
  output logic       saveReq,
  output logic       ackReq,
  output logic       handlerStart,
  output logic       floatEn
);

  localparam int LAST = SYNC_STAGES - 1;

  // Synchroniser: left without reset so it tracks the pin through reset,
  // which the strap capture depends on.
  logic [LAST:0] syncChain;
  logic          reqLevel;
  logic          prevLevel;
  logic          reqEdge;
  logic          strapDone;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) syncChain[0] <= ~intReqN;
      end else begin : g_next
        always_ff @(posedge clk) syncChain[g] <= syncChain[g-1];
      end
    end
  endgenerate

  assign reqLevel = syncChain[LAST];
  assign reqEdge  = reqLevel & ~prevLevel;

  // prevLevel resets high so a request held through reset is not an edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLevel  <= 1'b1;
      pendingReq <= 1'b0;
    end else begin
      prevLevel  <= reqLevel;
      pendingReq <= reqEdge | (pendingReq & ~strobe.clrPending);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      saveReq      <= 1'b0;
      ackReq       <= 1'b0;
      handlerStart <= 1'b0;
    end else begin
      saveReq      <= strobe.fireSave;
      ackReq       <= strobe.fireAck;
      handlerStart <= strobe.fireStart;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strapDone <= 1'b0;
      floatEn   <= 1'b0;
    end else if (!strapDone) begin
      strapDone <= 1'b1;
      floatEn   <= reqLevel;
    end
  end

  p_float_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    strapDone |=> $stable(floatEn));

  p_save_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    saveReq |=> !saveReq);

  p_ack_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    ackReq |=> !ackReq);

  p_start_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    handlerStart |=> !handlerStart);

endmodule

// File: rtl/mgmtControl.sv
module mgmtControl
  import mgmt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pendingReq,
  input  logic       saveDone,
  input  logic       ackDone,
  input  logic       resume,
  output seqStrobe_t strobe,
  output logic       mgmtActive
);

  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: if (pendingReq) begin
        nextState         = ST_SAVE_WAIT;
        strobe.fireSave   = 1'b1;
        strobe.clrPending = 1'b1;
      end
      ST_SAVE_WAIT: if (saveDone) begin
        nextState      = ST_ACK_WAIT;
        strobe.fireAck = 1'b1;
      end
      ST_ACK_WAIT: if (ackDone) begin
        nextState        = ST_MGMT;
        strobe.fireStart = 1'b1;
      end
      ST_MGMT: if (resume) nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign mgmtActive = (state != ST_IDLE);

  p_early_resume_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SAVE_WAIT || state == ST_ACK_WAIT) |=> state != ST_IDLE);

  p_stray_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |=> state != ST_ACK_WAIT && state != ST_MGMT);

endmodule

// File: rtl/mgmtIntSeq.sv
module mgmtIntSeq
  import mgmt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic intReqN,
  input  logic saveDone,
  input  logic ackDone,
  input  logic resume,
  output logic saveReq,
  output logic ackReq,
  output logic handlerStart,
  output logic mgmtActive,
  output logic floatEn
);

  seqStrobe_t strobe;
  logic       pendingReq;

  mgmtDatapath #(.SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk(clk), .rstN(rstN), .intReqN(intReqN), .strobe(strobe),
    .pendingReq(pendingReq), .saveReq(saveReq), .ackReq(ackReq),
    .handlerStart(handlerStart), .floatEn(floatEn)
  );

  mgmtControl i_ctl (
    .clk(clk), .rstN(rstN), .pendingReq(pendingReq), .saveDone(saveDone),
    .ackDone(ackDone), .resume(resume), .strobe(strobe), .mgmtActive(mgmtActive)
  );

  p_enter_from_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    saveReq |-> !$past(mgmtActive));

  p_active_on_save_r3: assert property (@(posedge clk) disable iff (!rstN)
    saveReq |-> mgmtActive);

  p_ack_after_save_r4: assert property (@(posedge clk) disable iff (!rstN)
    ackReq |-> $past(saveDone));

  p_start_after_ack_r5: assert property (@(posedge clk) disable iff (!rstN)
    handlerStart |-> $past(ackDone) && mgmtActive);

endmodule

// File: tb/test_mgmtIntSeq.sv
module test_mgmtIntSeq;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic intReqN = 1'b1;
  logic saveDone = 1'b0;
  logic ackDone = 1'b0;
  logic resume = 1'b0;
  logic saveReq, ackReq, handlerStart, mgmtActive, floatEn;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  mgmtIntSeq i_mgmtIntSeq (
    .clk(clk), .rstN(rstN), .intReqN(intReqN), .saveDone(saveDone),
    .ackDone(ackDone), .resume(resume), .saveReq(saveReq), .ackReq(ackReq),
    .handlerStart(handlerStart), .mgmtActive(mgmtActive), .floatEn(floatEn)
  );

  // Row layout: {saveLat[3:0], ackLat[3:0], extraEdges[3:0], expectReentry[3:0]}
  localparam int NVEC = 6;
  localparam logic [15:0] VECS [NVEC] = '{
    16'h0000, 16'h1000, 16'h3211, 16'h0421, 16'h5100, 16'h2231
  };

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishEntry();
    saveDone = 1'b1; step(); saveDone = 1'b0;
    chk("R4 ack after save", ackReq, 1);
    ackDone = 1'b1; step(); ackDone = 1'b0;
    chk("R5 start after ack", handlerStart, 1);
    resume = 1'b1; step(); resume = 1'b0;
    chk("R7 resume exits", mgmtActive, 0);
  endtask

  task automatic runSeq(input int saveLat, input int ackLat, input int extra, input int expRe);
    intReqN = 1'b0;
    repeat (3) step();
    chk("R2 no early saveReq", saveReq, 0);
    step();
    chk("R2 saveReq latency", saveReq, 1);
    chk("R3 active on entry", mgmtActive, 1);
    intReqN = 1'b1;
    step();
    chk("R3 saveReq one cycle", saveReq, 0);
    for (int i = 0; i < saveLat; i++) begin
      step();
      chk("R4 no ack before saveDone", ackReq, 0);
    end
    saveDone = 1'b1; step(); saveDone = 1'b0;
    chk("R4 ackReq pulse", ackReq, 1);
    step();
    chk("R4 ackReq one cycle", ackReq, 0);
    for (int i = 0; i < ackLat; i++) begin
      step();
      chk("R5 no start before ackDone", handlerStart, 0);
    end
    ackDone = 1'b1; step(); ackDone = 1'b0;
    chk("R5 handlerStart pulse", handlerStart, 1);
    step();
    chk("R5 handlerStart one cycle", handlerStart, 0);
    chk("R5 still active", mgmtActive, 1);
    for (int k = 0; k < extra; k++) begin
      intReqN = 1'b0; repeat (3) step();
      intReqN = 1'b1; repeat (3) step();
      chk("R7 no reaccept in mgmt", saveReq, 0);
    end
    resume = 1'b1; step(); resume = 1'b0;
    chk("R7 resume clears active", mgmtActive, 0);
    step();
    chk("R7 pending reentry", saveReq, expRe);
    if (expRe != 0) begin
      finishEntry();
      step();
      chk("R7 single reentry", saveReq, 0);
    end
    repeat (2) step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    chk("R1 saveReq in reset", saveReq, 0);
    chk("R1 floatEn in reset", floatEn, 0);
    rstN = 1'b1;
    step();
    chk("R1 ackReq after reset", ackReq, 0);
    chk("R1 handlerStart after reset", handlerStart, 0);
    chk("R1 mgmtActive after reset", mgmtActive, 0);
    chk("R9 no strap when idle", floatEn, 0);
    repeat (2) step();

    for (int v = 0; v < NVEC; v++) begin
      runSeq(int'(VECS[v][15:12]), int'(VECS[v][11:8]),
             int'(VECS[v][7:4]), int'(VECS[v][3:0]));
    end

    // R6: stray completions while idle
    saveDone = 1'b1; ackDone = 1'b1; step(); saveDone = 1'b0; ackDone = 1'b0;
    step();
    chk("R6 no ack from idle", ackReq, 0);
    chk("R6 no start from idle", handlerStart, 0);
    chk("R6 still idle", mgmtActive, 0);

    // R6 and R8: stray ackDone and resume while the save is awaited; request held low
    intReqN = 1'b0; repeat (4) step();
    chk("R2 entry for R6 test", saveReq, 1);
    ackDone = 1'b1; resume = 1'b1; step(); ackDone = 1'b0; resume = 1'b0;
    step();
    chk("R6 ackDone ignored in save wait", handlerStart, 0);
    chk("R8 resume ignored before mgmt", mgmtActive, 1);
    resume = 1'b1; step(); resume = 1'b0;
    chk("R8 resume ignored again", mgmtActive, 1);
    finishEntry();
    repeat (3) step();
    chk("R2 held level no reentry", saveReq, 0);
    chk("R2 held level stays idle", mgmtActive, 0);
    intReqN = 1'b1; repeat (3) step();

    // R9: strap captured from a request held across reset release
    rstN = 1'b0; intReqN = 1'b0;
    repeat (4) step();
    rstN = 1'b1;
    step();
    chk("R9 strap captured", floatEn, 1);
    for (int i = 0; i < 6; i++) begin
      step();
      chk("R9 strap starts no entry", saveReq | mgmtActive, 0);
    end
    intReqN = 1'b1; repeat (3) step();
    runSeq(1, 1, 0, 0);
    chk("R9 strap held", floatEn, 1);
    rstN = 1'b0; repeat (3) step();
    chk("R1 floatEn cleared by reset", floatEn, 0);
    rstN = 1'b1; step();
    chk("R9 clean strap", floatEn, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule